// File: doc/BRIEF.md
# Execution Unit Occupancy Interlock

This block sits between the decode stage and one execution unit. It keeps track of whether the unit can take a new operation in the current cycle. When it cannot, it raises a stall so that decode holds the waiting operation and everything behind it. No new fetch happens while the stall is high. The arithmetic is not modelled: an accepted operation's tag passes through a delay equal to the unit latency and comes back out as a one-cycle result pulse.

A parameter picks one of four unit organisations:
- a single copy that stays occupied for the whole latency;
- a unit split into a few internal stages, each holding an operation for several cycles;
- a fully pipelined unit that accepts every cycle;
- several identical copies of the occupied-for-the-whole-latency kind, with each new operation steered to a free copy.

The index of the copy that takes the operation is reported alongside the stall. The requester keeps the request and its tag stable while the stall is high.

Top module: `fu_lock`

## Requirements
- R1: With MODE unpipelined, an accepted operation keeps the unit busy for LATENCY cycles. A request presented in the cycle after an acceptance is stalled for LATENCY-1 cycles, which is 5 with the default latency of 6.
- R2: With MODE partial, the unit takes a new operation every ceil(LATENCY/STAGES) cycles. With the defaults (6 and 3), a back-to-back request is stalled for exactly 1 cycle.
- R3: With MODE full, a request is accepted in every cycle and the stall never rises.
- R4: With MODE replicated, each of the COPIES copies is busy for LATENCY cycles after it takes an operation. A request goes to the lowest-numbered free copy, and accIdx gives that copy's number. The stall rises only when all copies are busy.
- R5: stall is high only while reqValid is high and no capacity is free. A stalled request is accepted later with the tag it was held with.
- R6: For each acceptance, resValid is high for one cycle exactly LATENCY cycles later, and resTag then equals the tag that was accepted. resValid is low in every other cycle.
- R7: Synchronous reset (rst high) frees every copy and discards results still in flight. A request in the first cycle after reset is accepted without a stall.
- R8: In every mode except replicated, accIdx is 0 whenever a request is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Decode presents an operation this cycle |
| reqTag | input | TAG_W | Tag of the presented operation |
| stall | output | 1 | Unit cannot take the presented operation; hold it |
| accIdx | output | IDX_W | Copy that takes the operation (0 unless replicated) |
| resValid | output | 1 | Result pulse, LATENCY cycles after acceptance |
| resTag | output | TAG_W | Tag carried by the result pulse |

## Verification
Four instances, one per organisation, are driven at the same time with the same three request densities. Back-to-back requests expose each organisation's own stall length: 5, 1, 0, and, with two copies, 4 cycles after the second issue. Requests every third cycle fall between the unpipelined and partial initiation intervals, so they separate those two organisations. Requests every seventh cycle never collide, so any stall in that phase is an error. A reset in the middle of a busy phase, followed straight away by a request, shows that occupancy and in-flight results are cleared.

// File: rtl/fu_lock_pkg.sv
package fu_lock_pkg;

  // Organisation of the execution unit behind the interlock.
  typedef enum logic [1:0] {
    FU_UNPIPE  = 2'd0,
    FU_PARTIAL = 2'd1,
    FU_FULL    = 2'd2,
    FU_REPL    = 2'd3
  } fuMode_e;

  // Strobes from the occupancy control to the result datapath.
  typedef struct packed {
    logic load;   // an operation is accepted this cycle
    logic clear;  // discard everything in flight
  } fuStrobe_t;

endpackage

// File: rtl/fu_lock_ctrl.sv
module fu_lock_ctrl
  import fu_lock_pkg::*;
#(
  parameter fuMode_e MODE    = FU_UNPIPE,
  parameter int      LATENCY = 6,
  parameter int      STAGES  = 3,
  parameter int      COPIES  = 2,
  parameter int      IDX_W   = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reqValid,
  output logic             stall,
  output logic [IDX_W-1:0] accIdx,
  output fuStrobe_t        strobe
);

  // Cycles between two acceptances on one copy.
  localparam int II = (MODE == FU_UNPIPE || MODE == FU_REPL) ? LATENCY :
                      (MODE == FU_PARTIAL) ? (LATENCY + STAGES - 1) / STAGES : 1;
  localparam int NCTR = (MODE == FU_REPL) ? COPIES : 1;
  localparam int CW   = $clog2(LATENCY + 1);

  logic [CW-1:0]    busyCnt [NCTR];
  logic [NCTR-1:0]  freeVec;
  logic [IDX_W-1:0] pickIdx;
  logic             canAccept;

  // Lowest-numbered free copy wins.
  always_comb begin
    pickIdx = '0;
    for (int k = NCTR - 1; k >= 0; k--) begin
      if (freeVec[k]) pickIdx = IDX_W'(k);
    end
  end

  assign canAccept    = |freeVec;
  assign stall        = reqValid & ~canAccept;
  assign accIdx       = pickIdx;
  assign strobe.load  = reqValid & canAccept & ~rst;
  assign strobe.clear = rst;

  for (genvar i = 0; i < NCTR; i++) begin : g_copy
    assign freeVec[i] = (busyCnt[i] == '0);

    always_ff @(posedge clk) begin
      if (rst) begin
        busyCnt[i] <= '0;
      end else if (strobe.load && pickIdx == IDX_W'(i)) begin
        busyCnt[i] <= CW'(II - 1);
      end else if (busyCnt[i] != '0) begin
        busyCnt[i] <= busyCnt[i] - 1'b1;
      end
    end
  end

endmodule

// File: rtl/fu_lock_dp.sv
module fu_lock_dp
  import fu_lock_pkg::*;
#(
  parameter int LATENCY = 6,
  parameter int TAG_W   = 8
) (
  input  logic             clk,
  input  fuStrobe_t        strobe,
  input  logic [TAG_W-1:0] reqTag,
  output logic             resValid,
  output logic [TAG_W-1:0] resTag
);

  logic             vPipe [LATENCY];
  logic [TAG_W-1:0] tPipe [LATENCY];

  for (genvar s = 0; s < LATENCY; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (strobe.clear) begin
        vPipe[s] <= 1'b0;
        tPipe[s] <= '0;
      end else if (s == 0) begin
        vPipe[s] <= strobe.load;
        tPipe[s] <= strobe.load ? reqTag : '0;
      end else begin
        vPipe[s] <= vPipe[(s == 0) ? 0 : s - 1];
        tPipe[s] <= tPipe[(s == 0) ? 0 : s - 1];
      end
    end
  end

  assign resValid = vPipe[LATENCY-1];
  assign resTag   = tPipe[LATENCY-1];

endmodule

// File: rtl/fu_lock.sv
module fu_lock
  import fu_lock_pkg::*;
#(
  parameter fuMode_e MODE    = FU_UNPIPE,
  parameter int      LATENCY = 6,
  parameter int      STAGES  = 3,
  parameter int      COPIES  = 2,
  parameter int      TAG_W   = 8,
  localparam int     IDX_W   = (COPIES > 1) ? $clog2(COPIES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reqValid,
  input  logic [TAG_W-1:0] reqTag,
  output logic             stall,
  output logic [IDX_W-1:0] accIdx,
  output logic             resValid,
  output logic [TAG_W-1:0] resTag
);

  fuStrobe_t strobe;

  fu_lock_ctrl #(
    .MODE(MODE), .LATENCY(LATENCY), .STAGES(STAGES),
    .COPIES(COPIES), .IDX_W(IDX_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .reqValid(reqValid),
    .stall(stall), .accIdx(accIdx), .strobe(strobe)
  );

  fu_lock_dp #(.LATENCY(LATENCY), .TAG_W(TAG_W)) u_dp (
    .clk(clk), .strobe(strobe), .reqTag(reqTag),
    .resValid(resValid), .resTag(resTag)
  );

endmodule

// File: rtl/fu_lock_chk.sv
module fu_lock_chk
  import fu_lock_pkg::*;
#(
  parameter fuMode_e MODE    = FU_UNPIPE,
  parameter int      LATENCY = 6,
  parameter int      STAGES  = 3,
  parameter int      COPIES  = 2,
  parameter int      IDX_W   = 1
) (
  input logic             clk,
  input logic             rst,
  input logic             reqValid,
  input logic             stall,
  input logic [IDX_W-1:0] accIdx,
  input logic             resValid
);

  localparam int  NCTR   = (MODE == FU_REPL) ? COPIES : 1;
  localparam bit  SOLE   = (MODE == FU_UNPIPE) || (MODE == FU_PARTIAL);
  localparam bit  ISFULL = (MODE == FU_FULL);
  localparam bit  GAPPED = SOLE && (LATENCY > 1) && ((MODE == FU_UNPIPE) || (STAGES < LATENCY));

  logic [15:0] inFlight;
  logic        acc;
  assign acc = reqValid && !stall;

  always_ff @(posedge clk) begin
    if (rst) inFlight <= '0;
    else     inFlight <= inFlight + 16'(acc) - 16'(resValid);
  end

  p_stall_needs_req_r5: assert property (@(posedge clk) disable iff (rst)
    stall |-> reqValid);

  p_full_never_stalls_r3: assert property (@(posedge clk) disable iff (rst)
    (ISFULL && reqValid) |-> !stall);

  p_sole_busy_after_issue_r1: assert property (@(posedge clk) disable iff (rst)
    (GAPPED && acc) |=> (!reqValid || stall));

  p_result_has_source_r6: assert property (@(posedge clk) disable iff (rst)
    resValid |-> (inFlight != '0));

  p_idx_in_range_r4: assert property (@(posedge clk) disable iff (rst)
    acc |-> (int'(accIdx) < NCTR));

  p_accept_after_reset_r7: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && reqValid) |-> !stall);

endmodule

bind fu_lock fu_lock_chk #(
  .MODE(MODE), .LATENCY(LATENCY), .STAGES(STAGES),
  .COPIES(COPIES), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst(rst), .reqValid(reqValid), .stall(stall),
  .accIdx(accIdx), .resValid(resValid)
);

// File: tb/fu_lock_tb.sv
module fu_lock_tb;
  import fu_lock_pkg::*;

  localparam int LAT = 6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reqV  [4];
  logic [7:0] reqT  [4];
  logic       stallW[4];
  logic [0:0] idxW  [4];
  logic       resV  [4];
  logic [7:0] resT  [4];

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  fu_lock #(.MODE(FU_UNPIPE), .LATENCY(LAT), .STAGES(3), .COPIES(2)) u_dut (
    .clk(clk), .rst(rst), .reqValid(reqV[0]), .reqTag(reqT[0]), .stall(stallW[0]),
    .accIdx(idxW[0]), .resValid(resV[0]), .resTag(resT[0]));
  fu_lock #(.MODE(FU_PARTIAL), .LATENCY(LAT), .STAGES(3), .COPIES(2)) u_dut_part (
    .clk(clk), .rst(rst), .reqValid(reqV[1]), .reqTag(reqT[1]), .stall(stallW[1]),
    .accIdx(idxW[1]), .resValid(resV[1]), .resTag(resT[1]));
  fu_lock #(.MODE(FU_FULL), .LATENCY(LAT), .STAGES(3), .COPIES(2)) u_dut_full (
    .clk(clk), .rst(rst), .reqValid(reqV[2]), .reqTag(reqT[2]), .stall(stallW[2]),
    .accIdx(idxW[2]), .resValid(resV[2]), .resTag(resT[2]));
  fu_lock #(.MODE(FU_REPL), .LATENCY(LAT), .STAGES(3), .COPIES(2)) u_dut_repl (
    .clk(clk), .rst(rst), .reqValid(reqV[3]), .reqTag(reqT[3]), .stall(stallW[3]),
    .accIdx(idxW[3]), .resValid(resV[3]), .resTag(resT[3]));

  // Independent model: per copy, first cycle it is free again.
  int         iiOf[4]     = '{6, 2, 1, 6};
  int         copiesOf[4] = '{1, 1, 1, 2};
  string      modeReq[4]  = '{"R1", "R2", "R3", "R4"};
  int         nextFree[4][2];
  bit         expV[4][64];
  logic [7:0] expT[4][64];
  bit         pending[4];
  int         runLen[4];
  int         firstRun[4];
  int         cyc = 0;
  logic [7:0] nextTag = 8'd1;
  bit         justReset = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  function automatic bit wantReq(input int c);
    if (c < 80)  return 1'b1;
    if (c < 200) return (c % 3) == 0;
    if (c < 320) return (c % 7) == 0;
    return 1'b0;
  endfunction

  task automatic clearModel();
    for (int m = 0; m < 4; m++) begin
      for (int k = 0; k < 2; k++) nextFree[m][k] = 0;
      for (int s = 0; s < 64; s++) begin expV[m][s] = 1'b0; expT[m][s] = '0; end
      pending[m] = 1'b0;
      runLen[m]  = 0;
      reqV[m]    = 1'b0;
      reqT[m]    = '0;
    end
  endtask

  // Mid-cycle check of every unit, then model update.
  task automatic checkCycle();
    for (int m = 0; m < 4; m++) begin
      int freeK = -1;
      int slot  = cyc % 64;
      string sReq;
      for (int k = copiesOf[m] - 1; k >= 0; k--)
        if (nextFree[m][k] <= cyc) freeK = k;
      sReq = justReset ? "R7" : (reqV[m] ? modeReq[m] : "R5");
      check(stallW[m] == (reqV[m] && freeK < 0), sReq, int'(stallW[m]),
            int'(reqV[m] && freeK < 0));
      if (reqV[m] && freeK >= 0) begin
        check(int'(idxW[m]) == freeK, (m == 3) ? "R4" : "R8", int'(idxW[m]), freeK);
        expV[m][(cyc + LAT) % 64] = 1'b1;
        expT[m][(cyc + LAT) % 64] = reqT[m];
        nextFree[m][freeK] = cyc + iiOf[m];
        if (firstRun[m] < 0 && runLen[m] > 0) firstRun[m] = runLen[m];
        pending[m] = 1'b0;
        runLen[m]  = 0;
      end else if (reqV[m]) begin
        runLen[m]++;
      end
      check(resV[m] == expV[m][slot], justReset ? "R7" : "R6", int'(resV[m]), int'(expV[m][slot]));
      if (expV[m][slot])
        check(resT[m] == expT[m][slot], "R6", int'(resT[m]), int'(expT[m][slot]));
      expV[m][slot] = 1'b0;
    end
    justReset = 0;
    cyc++;
  endtask

  task automatic driveNext();
    for (int m = 0; m < 4; m++) begin
      if (!pending[m] && wantReq(cyc)) begin
        pending[m] = 1'b1;
        reqT[m]    = nextTag;
        nextTag    = nextTag + 8'd1;
      end
      reqV[m] = pending[m];
    end
  endtask

  initial begin
    for (int m = 0; m < 4; m++) firstRun[m] = -1;
    clearModel();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    for (int m = 0; m < 4; m++) begin
      check(stallW[m] == 1'b0, "R7", int'(stallW[m]), 0);
      check(resV[m] == 1'b0, "R7", int'(resV[m]), 0);
    end
    @(posedge clk); #1;
    while (cyc < 400) begin
      if (cyc == 151) begin
        // Reset while units are busy and results are in flight.
        rst = 1'b1;
        clearModel();
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        justReset = 1;
        for (int m = 0; m < 4; m++) begin
          pending[m] = 1'b1;
          reqT[m]    = nextTag;
          nextTag    = nextTag + 8'd1;
          reqV[m]    = 1'b1;
        end
      end else begin
        driveNext();
      end
      @(negedge clk);
      checkCycle();
      @(posedge clk); #1;
    end
    // Back-to-back stall lengths per organisation.
    check(firstRun[0] == 5, "R1", firstRun[0], 5);
    check(firstRun[1] == 1, "R2", firstRun[1], 1);
    check(firstRun[2] == -1, "R3", firstRun[2], -1);
    check(firstRun[3] == 4, "R4", firstRun[3], 4);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule